// File: doc/BRIEF.md
# Decimating complex FIR MAC engine

This block is a time-shared FIR filter for complex samples. I and Q samples arrive on a slow strobe and are written into a circular delay-line RAM. On every M-th input, at a selectable input phase, a sequencer walks the taps of one output, one tap per fast clock. Each tap reads one coefficient from an external coefficient RAM and one or two delay-line samples. There is one multiplier for the I path and one for the Q path. The accumulated sum is rounded and saturated, and is then presented with a one-cycle output strobe.

Several coefficient sets can live in the coefficient RAM at once, and the base offset picks one of them. The tap count, offset and symmetry mode are captured when an output computation starts, so the host may change them at any time. A change always takes effect from the next output. In symmetric mode, each stored coefficient serves a mirrored pair of taps: the two samples are added before the multiply, and the cycle count is halved. The decimation phase lets several instances split one polyphase filter between them. The number of multiplies per output is limited by the fast cycles available between outputs. Work beyond that limit is dropped and flagged.

The block assumes that `in_vld` pulses at most once every `CLK_PER_IN` fast cycles, with `CLK_PER_IN` at least 2. The block expects `cfg_phase` to be below the decimation factor. The coefficient RAM returns data one cycle after `coef_addr`. An output appears on `out_vld` at the edge that comes `used + 5` edges after the triggering input edge, where `used` is the number of multiplies.

Top module: `cplx_decim_fir`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_vld` and `err_budget` are 0.
- R2: The decimation factor is M = `cfg_dec_m1` + 1 (1..16). Counting inputs from 0 after reset, exactly the inputs with index k mod M equal to `cfg_phase` each produce one output, and no other output appears.
- R3: Asymmetric mode (`cfg_sym` = 0). With N = `cfg_ntaps_m1` + 1, N is capped at 64, and the output is the sum over j = 0..N-1 of coef[off + j] · x[k − j].
- R4: Symmetric mode (`cfg_sym` = 1). N may be up to 128, and the block uses ceil(N/2) multiplies. Multiply i uses coef[off + i] · (x[k − i] + x[k − (N−1−i)]). For odd N, the centre sample x[k − (N−1)/2] is added only once.
- R5: A delay-line sample with an index before the first input after reset (k − j < 0) counts as zero.
- R6: The coefficient offset is captured when the triggering input is accepted. A later change to the offset does not alter that output and applies from the next output.
- R7: The output is floor((acc + 2^(RSHIFT−1)) / 2^RSHIFT) clamped to the signed `OW`-bit range. With the defaults, RSHIFT is 15 and the clamp range is −32768..32767.
- R8: The multiply budget per output is `CLK_PER_IN`·M − 1 (default 8·M − 1). If the needed multiplies exceed it, only the first budget-many are summed and `err_budget` is set. Once set, `err_budget` stays set until reset.
- R9: Coefficient addresses run from `cfg_coef_off` upward by one per fast cycle, wrapping modulo 2^`CAW`. The coefficient data is used one cycle after its address.
- R10: `out_vld` is a single-cycle pulse, and `out_i`/`out_q` hold their value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast processing clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input sample strobe |
| in_i | input | DW | Input I sample, signed |
| in_q | input | DW | Input Q sample, signed |
| cfg_ntaps_m1 | input | log2(MAX_SYM) | Tap count minus one |
| cfg_coef_off | input | CAW | Coefficient base offset |
| cfg_sym | input | 1 | 1 = symmetric folding |
| cfg_dec_m1 | input | 4 | Decimation factor minus one |
| cfg_phase | input | 4 | Input phase that yields outputs |
| coef_addr | output | CAW | Coefficient RAM read address |
| coef_data | input | CW | Coefficient RAM data, one cycle after address |
| out_vld | output | 1 | Output strobe |
| out_i | output | OW | Output I sample |
| out_q | output | OW | Output Q sample |
| err_budget | output | 1 | Sticky multiply-budget overrun flag |

## Verification
Most internal faults show up in the value of the very next output. A wrong tap index, a mirrored-pair mistake, a stale or live offset, or a lost fill mask each corrupts the first affected output, at most `used + 5` cycles after its triggering input. A wrong phase counter or decimation count shows up as an output with the wrong value, or as a missing or unexpected strobe, within one decimation period. A budget fault shows up as a partial sum together with a wrong `err_budget` level at the end of the same run.

// File: rtl/cdf_pkg.sv
package cdf_pkg;
  // per-tap control travelling beside the data pipeline
  typedef struct packed {
    logic vld;
    logic first;
    logic last;
    logic use_a;
    logic use_b;
  } tap_ctl_t;
endpackage

// File: rtl/dfir_delay.sv
module dfir_delay #(
  parameter int DW    = 16,
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [2*DW-1:0]   wdata,
  input  logic [AW-1:0]     ra,
  input  logic [AW-1:0]     rb,
  output logic [2*DW-1:0]   qa,
  output logic [2*DW-1:0]   qb
);
  // one write port, two synchronous read ports, {Q,I} per word
  logic [2*DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    qa <= mem[ra];
    qb <= mem[rb];
  end
endmodule

// File: rtl/dfir_seq.sv
module dfir_seq
  import cdf_pkg::*;
#(
  parameter int TW         = 7,
  parameter int AW         = 8,
  parameter int CAW        = 7,
  parameter int DEPTH      = 256,
  parameter int MAX_ASYM   = 64,
  parameter int CLK_PER_IN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_vld,
  input  logic [TW-1:0]   cfg_ntaps_m1,
  input  logic [CAW-1:0]  cfg_coef_off,
  input  logic            cfg_sym,
  input  logic [3:0]      cfg_dec_m1,
  input  logic [3:0]      cfg_phase,
  output logic [AW-1:0]   waddr,
  output logic [AW-1:0]   ra,
  output logic [AW-1:0]   rb,
  output logic [CAW-1:0]  coef_addr,
  output tap_ctl_t        ctl,
  output logic            err
);
  localparam int UW = TW + 1;
  localparam int FW = AW + 1;

  logic [AW-1:0]  wp, base;
  logic [FW-1:0]  fill, fill_nx, nfill;
  logic [3:0]     ph_cnt;
  logic           busy, sym_r, trig, trunc;
  logic [UW-1:0]  n_eff, need, used, n_r, idx, last_r, jb;
  logic [CAW-1:0] off_r;
  int             budget;

  assign waddr   = wp;
  assign trig    = in_vld && (ph_cnt == cfg_phase);
  assign fill_nx = (fill == FW'(DEPTH)) ? fill : fill + 1'b1;
  assign jb      = n_r - idx - 1'b1;

  // taps needed versus fast cycles available before the next output
  always_comb begin
    n_eff = {1'b0, cfg_ntaps_m1} + 1'b1;
    if (!cfg_sym && n_eff > UW'(MAX_ASYM)) n_eff = UW'(MAX_ASYM);
    need   = cfg_sym ? ((n_eff + 1'b1) >> 1) : n_eff;
    budget = CLK_PER_IN * (int'(cfg_dec_m1) + 1) - 1;
    trunc  = int'(need) > budget;
    used   = trunc ? UW'(budget) : need;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp        <= '0;
      fill      <= '0;
      ph_cnt    <= '0;
      busy      <= 1'b0;
      err       <= 1'b0;
      ctl       <= '0;
      ra        <= '0;
      rb        <= '0;
      coef_addr <= '0;
      base      <= '0;
      nfill     <= '0;
      n_r       <= '0;
      idx       <= '0;
      last_r    <= '0;
      sym_r     <= 1'b0;
      off_r     <= '0;
    end else begin
      ctl <= '0;
      if (in_vld) begin
        wp     <= wp + 1'b1;
        fill   <= fill_nx;
        ph_cnt <= (ph_cnt == cfg_dec_m1) ? 4'd0 : ph_cnt + 1'b1;
      end
      if (busy) begin
        ra        <= base - AW'(idx);
        rb        <= base - AW'(jb);
        coef_addr <= off_r + CAW'(idx);
        ctl.vld   <= 1'b1;
        ctl.first <= (idx == '0);
        ctl.last  <= (idx == last_r);
        ctl.use_a <= FW'(idx) < nfill;
        ctl.use_b <= sym_r && (jb != idx) && (FW'(jb) < nfill);
        idx       <= idx + 1'b1;
        if (idx == last_r) busy <= 1'b0;
      end
      // configuration is frozen for the whole output here
      if (trig) begin
        busy   <= 1'b1;
        idx    <= '0;
        base   <= wp;
        nfill  <= fill_nx;
        n_r    <= n_eff;
        sym_r  <= cfg_sym;
        off_r  <= cfg_coef_off;
        last_r <= used - 1'b1;
        if (trunc) err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dfir_mac.sv
module dfir_mac
  import cdf_pkg::*;
#(
  parameter int DW     = 16,
  parameter int CW     = 16,
  parameter int OW     = 16,
  parameter int ACCW   = 40,
  parameter int RSHIFT = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  tap_ctl_t             ctl_in,
  input  logic [1:0][DW-1:0]   qa,
  input  logic [1:0][DW-1:0]   qb,
  input  logic signed [CW-1:0] coef,
  output logic                 out_vld,
  output logic [1:0][OW-1:0]   y
);
  localparam int PW = DW + 1 + CW;
  localparam int SW = ACCW + 1;
  localparam logic signed [SW-1:0] RND  = {{(SW-RSHIFT){1'b0}}, 1'b1, {(RSHIFT-1){1'b0}}};
  localparam logic signed [SW-1:0] MAXV = {{(SW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {{(SW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  function automatic logic [OW-1:0] rsat(input logic signed [ACCW-1:0] a);
    logic signed [SW-1:0] t;
    t = {a[ACCW-1], a};
    t = (t + RND) >>> RSHIFT;
    if (t > MAXV) return MAXV[OW-1:0];
    if (t < MINV) return MINV[OW-1:0];
    return t[OW-1:0];
  endfunction

  tap_ctl_t c1, c2, c3, c4;
  logic signed [CW-1:0] coef2;

  always_ff @(posedge clk) begin
    if (rst) begin
      c1 <= '0; c2 <= '0; c3 <= '0; c4 <= '0;
      out_vld <= 1'b0;
    end else begin
      c1 <= ctl_in;
      c2 <= c1;
      c3 <= c2;
      c4 <= c3;
      out_vld <= c4.vld && c4.last;
    end
  end

  always_ff @(posedge clk) coef2 <= coef;

  for (genvar p = 0; p < 2; p++) begin : g_path
    logic [DW-1:0]          a, b;
    logic signed [DW:0]     pre;
    logic signed [PW-1:0]   prod;
    logic signed [ACCW-1:0] acc, prod_x;
    logic [OW-1:0]          y_r;

    assign a      = c1.use_a ? qa[p] : '0;
    assign b      = c1.use_b ? qb[p] : '0;
    assign prod_x = {{(ACCW-PW){prod[PW-1]}}, prod};

    always_ff @(posedge clk) begin
      pre  <= {a[DW-1], a} + {b[DW-1], b};
      prod <= pre * coef2;
      if (c3.vld) acc <= c3.first ? prod_x : acc + prod_x;
    end

    always_ff @(posedge clk) begin
      if (rst) y_r <= '0;
      else if (c4.vld && c4.last) y_r <= rsat(acc);
    end

    assign y[p] = y_r;
  end
endmodule

// File: rtl/cplx_decim_fir.sv
module cplx_decim_fir
  import cdf_pkg::*;
#(
  parameter int DW         = 16,
  parameter int CW         = 16,
  parameter int OW         = 16,
  parameter int CAW        = 7,
  parameter int MAX_SYM    = 128,
  parameter int MAX_ASYM   = 64,
  parameter int DEPTH      = 256,
  parameter int CLK_PER_IN = 8,
  parameter int RSHIFT     = 15,
  localparam int TW        = $clog2(MAX_SYM),
  localparam int AW        = $clog2(DEPTH),
  localparam int ACCW      = DW + 1 + CW + TW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic [TW-1:0]        cfg_ntaps_m1,
  input  logic [CAW-1:0]       cfg_coef_off,
  input  logic                 cfg_sym,
  input  logic [3:0]           cfg_dec_m1,
  input  logic [3:0]           cfg_phase,
  output logic [CAW-1:0]       coef_addr,
  input  logic signed [CW-1:0] coef_data,
  output logic                 out_vld,
  output logic signed [OW-1:0] out_i,
  output logic signed [OW-1:0] out_q,
  output logic                 err_budget
);
  tap_ctl_t           ctl;
  logic [AW-1:0]      waddr, ra, rb;
  logic [2*DW-1:0]    qa, qb;
  logic [1:0][OW-1:0] y;
  logic               tap_vld, tap_first;

  assign tap_vld   = ctl.vld;
  assign tap_first = ctl.first;

  dfir_seq #(
    .TW(TW), .AW(AW), .CAW(CAW), .DEPTH(DEPTH),
    .MAX_ASYM(MAX_ASYM), .CLK_PER_IN(CLK_PER_IN)
  ) u_seq (
    .clk(clk), .rst(rst), .in_vld(in_vld),
    .cfg_ntaps_m1(cfg_ntaps_m1), .cfg_coef_off(cfg_coef_off),
    .cfg_sym(cfg_sym), .cfg_dec_m1(cfg_dec_m1), .cfg_phase(cfg_phase),
    .waddr(waddr), .ra(ra), .rb(rb), .coef_addr(coef_addr),
    .ctl(ctl), .err(err_budget)
  );

  dfir_delay #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_dly (
    .clk(clk), .we(in_vld), .waddr(waddr), .wdata({in_q, in_i}),
    .ra(ra), .rb(rb), .qa(qa), .qb(qb)
  );

  dfir_mac #(
    .DW(DW), .CW(CW), .OW(OW), .ACCW(ACCW), .RSHIFT(RSHIFT)
  ) u_mac (
    .clk(clk), .rst(rst), .ctl_in(ctl), .qa(qa), .qb(qb),
    .coef(coef_data), .out_vld(out_vld), .y(y)
  );

  assign out_i = y[0];
  assign out_q = y[1];
endmodule

// File: rtl/cplx_decim_fir_chk.sv
module cplx_decim_fir_chk #(
  parameter int OW  = 16,
  parameter int CAW = 7
) (
  input logic           clk,
  input logic           rst,
  input logic           out_vld,
  input logic [OW-1:0]  out_i,
  input logic [OW-1:0]  out_q,
  input logic           err,
  input logic           tap_vld,
  input logic           tap_first,
  input logic [CAW-1:0] coef_addr
);
  // R1: quiet right after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> (!out_vld && !err));

  // R8: overrun flag is sticky
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  // R10: strobe lasts one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_vld |=> !out_vld);

  // R10: outputs hold between strobes
  a_r10_hold_output: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> ($stable(out_i) && $stable(out_q)));

  // R9: coefficient address steps by one inside an output
  a_r9_coef_step: assert property (@(posedge clk) disable iff (rst)
    (tap_vld && !tap_first) |-> (coef_addr == CAW'($past(coef_addr) + 1'b1)));
endmodule

bind cplx_decim_fir cplx_decim_fir_chk #(.OW(OW), .CAW(CAW)) u_chk (
  .clk(clk), .rst(rst), .out_vld(out_vld), .out_i(out_i), .out_q(out_q),
  .err(err_budget), .tap_vld(tap_vld), .tap_first(tap_first),
  .coef_addr(coef_addr)
);

// File: tb/cplx_decim_fir_tb.sv
module cplx_decim_fir_tb;
  localparam int DW = 16, CW = 16, OW = 16, CAW = 7, TW = 7, CPS = 8;

  logic clk = 1'b0, rst = 1'b1, in_vld = 1'b0;
  logic signed [DW-1:0] in_i = '0, in_q = '0;
  logic [TW-1:0]  cfg_ntaps_m1 = '0;
  logic [CAW-1:0] cfg_coef_off = '0;
  logic           cfg_sym = 1'b0;
  logic [3:0]     cfg_dec_m1 = '0, cfg_phase = '0;
  logic [CAW-1:0] coef_addr;
  logic signed [CW-1:0] coef_data = '0;
  logic           out_vld, err_budget;
  logic signed [OW-1:0] out_i, out_q;

  always #5 clk = ~clk;

  cplx_decim_fir u_dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_i(in_i), .in_q(in_q),
    .cfg_ntaps_m1(cfg_ntaps_m1), .cfg_coef_off(cfg_coef_off),
    .cfg_sym(cfg_sym), .cfg_dec_m1(cfg_dec_m1), .cfg_phase(cfg_phase),
    .coef_addr(coef_addr), .coef_data(coef_data), .out_vld(out_vld),
    .out_i(out_i), .out_q(out_q), .err_budget(err_budget)
  );

  logic signed [CW-1:0] cram [0:127];
  always @(posedge clk) coef_data <= cram[coef_addr];

  int xi [0:255];
  int xq [0:255];
  longint qi[$], qq[$];
  int checks = 0, fails = 0;
  string cur_req = "";
  bit exp_err = 1'b0, prev_vld = 1'b0, swap_off = 1'b0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint xv(int j, bit q);
    if (j < 0) return 0;
    return q ? longint'(xq[j]) : longint'(xi[j]);
  endfunction

  function automatic longint rsat(longint a);
    longint t;
    t = (a + 16384) >>> 15;
    if (t > 32767) return 32767;
    if (t < -32768) return -32768;
    return t;
  endfunction

  task automatic push_exp(int k);
    int n, m, need, bud, used;
    longint ai, aq;
    n = int'(cfg_ntaps_m1) + 1;
    m = int'(cfg_dec_m1) + 1;
    if (!cfg_sym && n > 64) n = 64;
    need = cfg_sym ? (n + 1) / 2 : n;
    bud  = CPS * m - 1;
    used = (need < bud) ? need : bud;
    if (used < need) exp_err = 1'b1;
    ai = 0; aq = 0;
    for (int t = 0; t < used; t++) begin
      longint c, si, sq;
      int jb;
      c  = longint'(cram[(int'(cfg_coef_off) + t) % 128]);
      jb = n - 1 - t;
      si = xv(k - t, 1'b0);
      sq = xv(k - t, 1'b1);
      if (cfg_sym && jb != t) begin
        si += xv(k - jb, 1'b0);
        sq += xv(k - jb, 1'b1);
      end
      ai += c * si;
      aq += c * sq;
    end
    qi.push_back(rsat(ai));
    qq.push_back(rsat(aq));
  endtask

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (!rst && out_vld) begin
      chk(!prev_vld, "R10", "strobe longer than one cycle", prev_vld, 0);
      if (qi.size() == 0) chk(1'b0, "R2", "unexpected output strobe", 1, 0);
      else begin
        longint ei, eq;
        ei = qi.pop_front();
        eq = qq.pop_front();
        chk(out_i == ei, cur_req, "I output", out_i, ei);
        chk(out_q == eq, cur_req, "Q output", out_q, eq);
      end
    end
    prev_vld = out_vld;
  end

  task automatic send(int k);
    int m;
    bit trig;
    m    = int'(cfg_dec_m1) + 1;
    trig = (k % m) == int'(cfg_phase);
    in_i = xi[k][DW-1:0];
    in_q = xq[k][DW-1:0];
    in_vld = 1'b1;
    if (trig) push_exp(k);
    @(negedge clk);
    in_vld = 1'b0;
    if (trig && swap_off) cfg_coef_off = (cfg_coef_off == 0) ? 7'd40 : 7'd0;
    repeat (CPS - 1) @(negedge clk);
  endtask

  task automatic run(string req, int n, bit sym, int m, int ph, int off,
                     int nsamp, int pat, bit swp);
    cur_req  = req;
    swap_off = swp;
    exp_err  = 1'b0;
    for (int a = 0; a < 128; a++)
      cram[a] = (pat == 1) ? 16'sd32767 : CW'(((a * 531 + 77) % 8001) - 4000);
    for (int k = 0; k < 256; k++) begin
      if (pat == 1) begin
        xi[k] = ((k / 6) % 2 == 0) ? 32767 : -32768;
        xq[k] = ((k / 6) % 2 == 0) ? -32768 : 32767;
      end else begin
        xi[k] = ((k * 97 + 13) % 2001) - 1000;
        xq[k] = ((k * 61 + 400) % 1777) - 888;
      end
    end
    cfg_ntaps_m1 = TW'(n - 1);
    cfg_sym      = sym;
    cfg_dec_m1   = 4'(m - 1);
    cfg_phase    = 4'(ph);
    cfg_coef_off = CAW'(off);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_vld == 1'b0, "R1", "strobe after reset", out_vld, 0);
    chk(err_budget == 1'b0, "R1", "error flag after reset", err_budget, 0);
    for (int k = 0; k < nsamp; k++) send(k);
    repeat (160) @(negedge clk);
    chk(qi.size() == 0, "R2", "outputs still missing", qi.size(), 0);
    qi.delete();
    qq.delete();
    chk(err_budget == exp_err, "R8", "budget error flag", err_budget, exp_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // decimation factor and phase sweep (R2 R3 R9)
    for (int m = 1; m <= 4; m++)
      for (int ph = 0; ph < m; ph++)
        run("R2 R3 R9", 4, 1'b0, m, ph, ph * 5, 24, 0, 1'b0);
    run("R3 R5 R9", 16, 1'b0, 4, 2, 10, 64, 0, 1'b0);
    run("R3 R5", 64, 1'b0, 16, 15, 3, 96, 0, 1'b0);
    run("R3 R8", 100, 1'b0, 16, 0, 0, 64, 0, 1'b0);   // capped at 64 taps
    run("R4 R5", 7, 1'b1, 2, 1, 20, 40, 0, 1'b0);     // odd, centre once
    run("R4 R9", 10, 1'b1, 1, 0, 125, 30, 0, 1'b0);   // address wraps
    run("R4 R5", 128, 1'b1, 16, 5, 64, 96, 0, 1'b0);
    run("R7", 4, 1'b0, 1, 0, 0, 30, 1, 1'b0);         // clamp both ways
    run("R8", 20, 1'b0, 2, 0, 0, 40, 0, 1'b0);        // 20 > 15 budget
    run("R8 R4", 40, 1'b1, 2, 1, 0, 40, 0, 1'b0);     // 20 pairs > 15
    run("R6", 6, 1'b0, 2, 0, 0, 40, 0, 1'b1);         // offset moves mid-output
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule